// File: doc/BRIEF.md
# Integrate-and-Dump Decimator with Gain Shifter

This block lowers the sample rate of an 8-bit two's complement I/Q stream by a programmable factor R = 2N, with N = 1, 2, 4, 8 or 16. Valid input samples are first grouped in non-overlapping pairs. Each pair is added with one extra fractional bit, so the pair summer has unity gain relative to the pair average. An accumulator then integrates N pair values. On the last pair of a group it dumps the total and restarts from the next pair. A right shifter of 0 to 4 bits, with rounding, compensates for the accumulator's gain of N. A saturating limiter then produces a 10-bit output word. The output carries a one-cycle valid pulse for each decimated sample.

A bypass mode turns off integration and decimation. Every valid input sample appears at the output with unity gain, and a half-LSB bit below the input LSB is forced to one. The I and Q lanes share one control sequencer and are processed identically.

Output units are half an input LSB throughout. In the enabled mode a dumped value is the sum of the 2N raw samples, shifted and rounded. In bypass a sample x appears as 2x+1.

Top module: `idd_decimator`

## Requirements
- R1: While reset is held and after its release, before any group completes, `outValid` is 0 and `outI`/`outQ` read 0.
- R2: With integration enabled, valid samples are taken in consecutive pairs (x0, x1), and each pair contributes the value x0+x1 to the accumulator.
- R3: `decSel` = k (0..4) sets N = 2^k pair values per group, that is R = 2^(k+1) valid samples per output. Codes above 4 act as 4. Exactly one output is produced per group, and the accumulator starts over with the next pair, so no sample is lost.
- R4: `shiftSel` = s (0..4) gives the output floor((A + 2^(s-1)) / 2^s) for s ≥ 1, where A is the group sum, and A itself for s = 0. Codes above 4 act as 4.
- R5: The shifted value is saturated to the signed 10-bit range [-512, 511].
- R6: `outValid` pulses for one cycle. It rises in the cycle after the valid sample that completes a group. In the enabled mode it is never high two cycles in a row, and `outI`/`outQ` hold their value between pulses.
- R7: With `idEnable` = 0, each valid sample x raises `outValid` in the next cycle with output 2x+1, sign-extended. `shiftSel` has no effect, and the pairing and group state is cleared.
- R8: Cycles with `inValid` = 0 neither advance the pairing nor change the accumulator.
- R9: In the enabled mode, any cycle in which `decSel` differs from its value in the previous cycle discards that cycle's sample and restarts grouping. The next valid sample becomes the first sample of a new pair and group. After reset the previous value counts as 0.
- R10: The Q lane applies exactly the same processing as the I lane, driven by the same strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | 8 | In-phase sample, two's complement |
| inQ | input | 8 | Quadrature sample, two's complement |
| idEnable | input | 1 | 1 = integrate and dump, 0 = bypass |
| decSel | input | 3 | log2 of pair values per group (0..4) |
| shiftSel | input | 3 | Right shift after accumulation (0..4) |
| outI | output | 10 | In-phase result, half-LSB units |
| outQ | output | 10 | Quadrature result, half-LSB units |
| outValid | output | 1 | One-cycle dump / output strobe |

## Verification
The assertions check, on every cycle, that the group counter stays below N while `decSel` is steady. They also check that enabled-mode dump pulses never occur back to back, that the outputs stay still except on a load strobe, and that a bypassed word has its forced half-LSB and the input's sign. The exact arithmetic is shown only by the bench's sweep over every decimation and shift code against arithmetically computed sums: rounding, saturation at both rails, the restart on a decimation change, and that gaps in the stream have no effect.

// File: rtl/idd_pkg.sv
package idd_pkg;
  // Strobes from the sequencer to each datapath lane
  typedef struct packed {
    logic holdFirst;  // capture first sample of a pair
    logic pairDone;   // second sample of a pair is present
    logic accLoad;    // pair starts a new group: load instead of add
    logic dump;       // pair ends the group: produce output
    logic passOut;    // bypass: pass this sample to the output
  } iddCtrl_t;
endpackage

// File: rtl/idd_ctrl.sv
module idd_ctrl
  import idd_pkg::*;
#(
  parameter int MAX_LOG_N = 4,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             idEnable,
  input  logic [SEL_W-1:0] decSel,
  output iddCtrl_t         ctrl,
  output logic             outValid
);
  localparam int CNT_W = (MAX_LOG_N > 0) ? MAX_LOG_N : 1;

  logic             phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic [SEL_W-1:0] decSelQ;
  logic [SEL_W-1:0] logK;
  logic             restart;
  logic             take;

  always_comb begin
    logK    = (decSel > SEL_W'(MAX_LOG_N)) ? SEL_W'(MAX_LOG_N) : decSel;
    lastCnt = CNT_W'((32'd1 << logK) - 32'd1);
    restart = (decSel != decSelQ);
    take    = inValid && idEnable && !restart;
    ctrl.holdFirst = take && !phase;
    ctrl.pairDone  = take && phase;
    ctrl.accLoad   = take && phase && (cnt == '0);
    ctrl.dump      = take && phase && (cnt == lastCnt);
    ctrl.passOut   = inValid && !idEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= 1'b0;
      cnt      <= '0;
      decSelQ  <= '0;
      outValid <= 1'b0;
    end else begin
      decSelQ  <= decSel;
      outValid <= ctrl.dump || ctrl.passOut;
      if (restart || !idEnable) begin
        phase <= 1'b0;
        cnt   <= '0;
      end else if (take) begin
        phase <= !phase;
        if (ctrl.pairDone) cnt <= ctrl.dump ? '0 : cnt + CNT_W'(1);
      end
    end
  end

  // R3: group position never reaches N while the selection is steady
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!restart && idEnable) |-> (cnt <= lastCnt));

  // R6: in integrate mode a dump pulse is never followed by another
  p_dump_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && idEnable && $past(idEnable)) |=> !outValid);
endmodule

// File: rtl/idd_lane.sv
module idd_lane
  import idd_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 10,
  parameter int MAX_LOG_N = 4,
  parameter int MAX_SHIFT = 4,
  parameter int SH_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  iddCtrl_t          ctrl,
  input  logic [IN_W-1:0]   inX,
  input  logic [SH_W-1:0]   shiftSel,
  output logic [OUT_W-1:0]  outX
);
  localparam int PAIR_W = IN_W + 1;
  localparam int ACC_W  = PAIR_W + MAX_LOG_N;
  localparam int RND_W  = ACC_W + 1;
  localparam logic signed [RND_W-1:0] OUT_MAX = RND_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [RND_W-1:0] OUT_MIN = ~OUT_MAX;

  logic        [IN_W-1:0]   holdX;
  logic signed [PAIR_W-1:0] pairSum;
  logic signed [ACC_W-1:0]  accQ;
  logic signed [ACC_W-1:0]  accNext;
  logic signed [RND_W-1:0]  accExt;
  logic signed [RND_W-1:0]  rndBias;
  logic signed [RND_W-1:0]  rounded;
  logic        [SH_W-1:0]   shAmt;
  logic        [OUT_W-1:0]  satVal;
  logic        [OUT_W-1:0]  bypassVal;

  always_comb begin
    pairSum = {holdX[IN_W-1], holdX} + {inX[IN_W-1], inX};
    accNext = {{MAX_LOG_N{pairSum[PAIR_W-1]}}, pairSum};
    if (!ctrl.accLoad) accNext = accQ + accNext;
    accExt  = {accNext[ACC_W-1], accNext};
    shAmt   = (shiftSel > SH_W'(MAX_SHIFT)) ? SH_W'(MAX_SHIFT) : shiftSel;
    rndBias = (shAmt == '0) ? '0 : (RND_W'(1) << (shAmt - SH_W'(1)));
    rounded = (accExt + rndBias) >>> shAmt;
    if (rounded > OUT_MAX)      satVal = OUT_MAX[OUT_W-1:0];
    else if (rounded < OUT_MIN) satVal = OUT_MIN[OUT_W-1:0];
    else                        satVal = rounded[OUT_W-1:0];
    bypassVal = {{(OUT_W-IN_W-1){inX[IN_W-1]}}, inX, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdX <= '0;
      accQ  <= '0;
      outX  <= '0;
    end else begin
      if (ctrl.holdFirst) holdX <= inX;
      if (ctrl.pairDone)  accQ  <= accNext;
      if (ctrl.dump)         outX <= satVal;
      else if (ctrl.passOut) outX <= bypassVal;
    end
  end

  // R6: the output word moves only on a load strobe
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.dump && !ctrl.passOut) |=> $stable(outX));

  // R7: a bypassed word carries the forced half-LSB and the input sign
  p_bypass_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.passOut |=> (outX[0] && (outX[OUT_W-1] == $past(inX[IN_W-1]))));
endmodule

// File: rtl/idd_decimator.sv
module idd_decimator
  import idd_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 10,
  parameter int MAX_LOG_N = 4,
  parameter int MAX_SHIFT = 4,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inI,
  input  logic [IN_W-1:0]  inQ,
  input  logic             idEnable,
  input  logic [SEL_W-1:0] decSel,
  input  logic [SEL_W-1:0] shiftSel,
  output logic [OUT_W-1:0] outI,
  output logic [OUT_W-1:0] outQ,
  output logic             outValid
);
  localparam int LANES = 2;

  iddCtrl_t         ctrl;
  logic [IN_W-1:0]  laneIn  [LANES];
  logic [OUT_W-1:0] laneOut [LANES];

  assign laneIn[0] = inI;
  assign laneIn[1] = inQ;
  assign outI = laneOut[0];
  assign outQ = laneOut[1];

  idd_ctrl #(.MAX_LOG_N(MAX_LOG_N), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .idEnable(idEnable),
    .decSel(decSel), .ctrl(ctrl), .outValid(outValid)
  );

  // R10: identical lanes for I and Q
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    idd_lane #(
      .IN_W(IN_W), .OUT_W(OUT_W), .MAX_LOG_N(MAX_LOG_N),
      .MAX_SHIFT(MAX_SHIFT), .SH_W(SEL_W)
    ) u_lane (
      .clk(clk), .rstN(rstN), .ctrl(ctrl), .inX(laneIn[g]),
      .shiftSel(shiftSel), .outX(laneOut[g])
    );
  end
endmodule

// File: tb/sim_idd_decimator.sv
`timescale 1ns/1ps
module sim_idd_decimator;
  localparam int MAX_SHIFT = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, inValid, idEnable, outValid;
  logic [7:0] inI, inQ;
  logic [2:0] decSel, shiftSel;
  logic [9:0] outI, outQ;

  idd_decimator u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .idEnable(idEnable), .decSel(decSel), .shiftSel(shiftSel),
    .outI(outI), .outQ(outQ), .outValid(outValid)
  );

  int checks = 0, failures = 0;
  int expI[$], expQ[$];
  string expTag[$];
  bit monOn = 0, done = 0;
  int lastI = 0, lastQ = 0;

  // model state
  int prevDec = 0, phase = 0, cnt = 0, holdI = 0, holdQ = 0, accI = 0, accQ = 0;
  int seed = 12345;
  bit cfgEn = 1;
  int cfgDec = 0, cfgShift = 0;
  string curTag = "R3";

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return ((seed >> 16) & 255) - 128;
  endfunction

  function automatic int shapeOut(int a, int s);
    int ss = (s > MAX_SHIFT) ? MAX_SHIFT : s;
    int y = (ss == 0) ? a : ((a + (1 << (ss - 1))) >>> ss);
    if (y > 511) y = 511;
    if (y < -512) y = -512;
    return y;
  endfunction

  task automatic drive(bit v, int xi, int xq);
    int n;
    @(negedge clk);
    inValid = v; inI = xi[7:0]; inQ = xq[7:0];
    idEnable = cfgEn; decSel = cfgDec[2:0]; shiftSel = cfgShift[2:0];
    n = 1 << ((cfgDec > 4) ? 4 : cfgDec);
    if (!cfgEn) begin
      phase = 0; cnt = 0;
      if (v) begin expI.push_back(2*xi+1); expQ.push_back(2*xq+1); expTag.push_back("R7"); end
    end else if (cfgDec != prevDec) begin
      phase = 0; cnt = 0;  // R9: sample discarded
    end else if (v) begin
      if (phase == 0) begin holdI = xi; holdQ = xq; phase = 1; end
      else begin
        phase = 0;
        if (cnt == 0) begin accI = holdI + xi; accQ = holdQ + xq; end
        else begin accI += holdI + xi; accQ += holdQ + xq; end
        if (cnt == n - 1) begin
          expI.push_back(shapeOut(accI, cfgShift));
          expQ.push_back(shapeOut(accQ, cfgShift));
          expTag.push_back(curTag);
          cnt = 0;
        end else cnt++;
      end
    end
    prevDec = cfgDec;
  endtask

  // output monitor (R6 hold and comparisons, R10 on Q)
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (expI.size() == 0) begin
          checks++; failures++;
          $display("FAIL R6 unexpected pulse actual=1 expected=0");
        end else begin
          string t = expTag.pop_front();
          check({t, " I"}, int'($signed(outI)), expI.pop_front());
          check({t, " Q R10"}, int'($signed(outQ)), expQ.pop_front());
        end
        lastI = int'($signed(outI)); lastQ = int'($signed(outQ));
      end else begin
        check("R6 hold I", int'($signed(outI)), lastI);
        check("R6 hold Q", int'($signed(outQ)), lastQ);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int decs[6] = '{0, 1, 2, 3, 4, 7};
    int shs[6]  = '{0, 1, 2, 3, 4, 6};
    rstN = 0; inValid = 0; inI = 0; inQ = 0; idEnable = 1; decSel = 0; shiftSel = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", outValid, 0);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    check("R1 valid", outValid, 0);
    check("R1 outI", int'($signed(outI)), 0);
    check("R1 outQ", int'($signed(outQ)), 0);
    monOn = 1;

    // sweep every decimation and shift code, with gaps (R2 R3 R4 R8)
    foreach (decs[a]) begin
      foreach (shs[b]) begin
        int n;
        cfgEn = 1; cfgDec = decs[a]; cfgShift = shs[b];
        curTag = (cfgDec == 0 && cfgShift == 0) ? "R2" : (b == 5 || a == 5) ? "R3 R4 clamp" : "R4";
        drive(0, 0, 0);
        n = 1 << ((cfgDec > 4) ? 4 : cfgDec);
        for (int g = 0; g < 2; g++)
          for (int k = 0; k < 2 * n; k++) begin
            drive(1, rnd8(), rnd8());
            if (k % 5 == 4) drive(0, rnd8(), rnd8());  // R8 gap
          end
      end
    end
    repeat (3) drive(0, 0, 0);

    // saturation at both rails (R5)
    cfgDec = 4; cfgShift = 0; curTag = "R5";
    drive(0, 0, 0);
    for (int k = 0; k < 32; k++) drive(1, 127, -128);
    for (int k = 0; k < 32; k++) drive(1, -128, 127);
    repeat (3) drive(0, 0, 0);

    // bypass (R7), shift set but ignored
    cfgEn = 0; cfgShift = 3;
    drive(1, -128, 127); drive(1, 127, -128); drive(1, 0, -1); drive(0, 5, 5);
    for (int k = 0; k < 20; k++) begin
      drive(1, rnd8(), rnd8());
      if (k % 3 == 2) drive(0, 1, 1);
    end
    repeat (3) drive(0, 0, 0);

    // restart on decimation change (R9)
    cfgEn = 1; cfgDec = 1; cfgShift = 1; curTag = "R9";
    drive(0, 0, 0);
    drive(1, 50, -50);
    cfgDec = 2; drive(1, 100, 100);
    for (int k = 0; k < 8; k++) drive(1, rnd8(), rnd8());
    for (int k = 0; k < 6; k++) drive(1, rnd8(), rnd8());
    cfgDec = 1; drive(1, 90, -90);
    for (int k = 0; k < 4; k++) drive(1, rnd8(), rnd8());
    // leaving bypass mid-pair clears grouping (R7)
    cfgEn = 1; drive(1, 7, 7);
    cfgEn = 0; drive(0, 0, 0);
    cfgEn = 1; curTag = "R7 resume";
    for (int k = 0; k < 4; k++) drive(1, rnd8(), rnd8());
    repeat (4) drive(0, 0, 0);

    check("R3 all groups produced", expI.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule